// File: doc/BRIEF.md
# Aligned Payload Burst Packer

This block sits behind the packet input of a transport stream demultiplexer and turns a byte stream of accepted 188-byte transport packets into aligned burst writes toward system memory. It discards the four header bytes of every packet and gathers the 184 payload bytes into one of three staging lanes chosen by a stream-class tag: video, audio or table. Each lane has its own base address, region size and write offset. Payload that does not fill a burst carries over into the next packet of the same class.

A lane requests a write as soon as it holds one aligned burst. In low-bandwidth mode a burst is 32 bytes, and otherwise it is 128 bytes. Only one write is outstanding at a time. A simple responder completes each write with a one-cycle done pulse. When more than one lane is waiting, the lanes are served in round-robin order. A lane that is waiting stalls input for its own class only. A flush pulse pushes out the partly filled lanes, padded with zero bytes, and marks each with its real byte count.

Top module: `payload_burst_packer`

## Requirements
- R1: The byte accepted with `in_sop` high is packet byte 0. Packet bytes 0 to 3 are discarded and bytes 4 to 187 are packed. Bytes after byte 187, and bytes before the first `in_sop`, are discarded.
- R2: The burst size is 32 bytes when `cfg_low_bw` is 1 and 128 bytes when it is 0. A lane that reaches the burst size issues a burst with `wr_count` equal to that size.
- R3: The k-th payload byte of a burst, counting from 0, appears on `wr_data[8k+7:8k]`, in the order the bytes were accepted.
- R4: Class code 0 is video, 1 is audio and 2 is table. Each class packs into its own lane. Bytes tagged with class 3 are accepted (`in_ready` is 1) and discarded.
- R5: A partial burst left at the end of a packet is kept and continued by the next packet of the same class.
- R6: `wr_addr` equals `cfg_base[c] + offset[c]`. The offset starts at 0 and grows by the burst size after each burst of class c. It returns to 0 when the new value would be greater than or equal to `cfg_size[c]`.
- R7: A one-cycle `flush` marks every lane that holds at least one byte. Each marked lane issues one burst with `wr_count` equal to its byte count, and zero bytes above that count. The offset still advances by a full burst. A flush applied to empty lanes issues nothing.
- R8: `in_ready` is 0 while the lane selected by `in_class` holds a full burst or a pending flush that has not yet been granted. Input for the other classes is not affected.
- R9: Once `wr_req` rises, it stays high with `wr_addr`, `wr_data` and `wr_count` stable until a cycle with `wr_done` high. It is low in the following cycle.
- R10: When several lanes are waiting, the grant goes to the next waiting class after the last class granted, in the cyclic order 0, 1, 2. After reset, class 0 has the highest priority.
- R11: After reset, `wr_req` is 0, every lane is empty with `in_ready` at 1, and every offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_low_bw | input | 1 | 1 selects 32-byte bursts, 0 selects 128-byte bursts |
| cfg_base | input | 3x16 | Region base address for each class |
| cfg_size | input | 3x16 | Region size in bytes for each class |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when high with in_valid |
| in_data | input | 8 | Input byte |
| in_class | input | 2 | Stream class of the input byte |
| in_sop | input | 1 | Marks the first byte of a packet |
| flush | input | 1 | Forces out the partly filled lanes |
| wr_req | output | 1 | Burst write request |
| wr_addr | output | 16 | Burst byte address |
| wr_data | output | 1024 | Burst data, byte 0 in the low bits |
| wr_count | output | 8 | Number of valid bytes in the burst |
| wr_done | input | 1 | Completes the outstanding burst |

## Verification
The in-line assertions check on every cycle that the request is held stable until it completes, that it drops after completion, that no lane grows past the burst size, that bytes enter a lane only while it is ready, that the header counter stays in range and that grants are one-hot and go only to a waiting lane. Payload order, header stripping, carry-over between packets, zero padding after a flush, address wrap-around and the round-robin grant order depend on whole sequences of traffic. Only the bench shows these, by comparing every burst against a byte-level model for both burst sizes.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
    localparam int PBP_NCLS = 3;

    typedef enum logic [1:0] {
        CLS_VIDEO = 2'd0,
        CLS_AUDIO = 2'd1,
        CLS_TABLE = 2'd2,
        CLS_DROP  = 2'd3
    } pbp_cls_e;
endpackage

// File: rtl/pbp_hdr_strip.sv
module pbp_hdr_strip #(
    parameter int PKT_BYTES = 188,
    parameter int HDR_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic sop,
    output logic pay
);
    localparam int IW = $clog2(PKT_BYTES + 1);
    localparam logic [IW-1:0] PKT_L = IW'(PKT_BYTES);
    localparam logic [IW-1:0] HDR_L = IW'(HDR_BYTES);

    typedef struct packed {
        logic [IW-1:0] idx;
    } st_t;

    st_t s_d, s_q;
    logic [IW-1:0] pos;

    always_comb begin
        s_d = s_q;
        pos = sop ? '0 : s_q.idx;
        pay = acc && (pos >= HDR_L) && (pos < PKT_L);
        if (acc && (pos < PKT_L)) begin
            s_d.idx = pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.idx <= PKT_L;
        end else begin
            s_q <= s_d;
        end
    end

    // R1: the position counter never runs past the packet length
    a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= PKT_L);
    // R1: a start-of-packet byte is always header
    a_r1_sop_is_header: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sop) |-> !pay);
endmodule

// File: rtl/pbp_lane.sv
module pbp_lane #(
    parameter int MAX_BURST = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [7:0]               push_byte,
    input  logic [CW-1:0]            burst_len,
    input  logic                     flush,
    input  logic                     take,
    output logic                     ready,
    output logic                     want,
    output logic [CW-1:0]            fill,
    output logic [MAX_BURST*8-1:0]   data
);
    localparam int CW = $clog2(MAX_BURST + 1);
    localparam int BW = $clog2(MAX_BURST);

    typedef struct packed {
        logic [MAX_BURST*8-1:0] data;
        logic [CW-1:0]          fill;
        logic                   fpend;
    } st_t;

    st_t s_d, s_q;
    logic [BW-1:0] wi;
    logic full;

    always_comb begin
        s_d = s_q;
        wi  = s_q.fill[BW-1:0];
        if (take) begin
            s_d.data  = '0;
            s_d.fill  = '0;
            s_d.fpend = 1'b0;
        end else begin
            if (push) begin
                s_d.data[{wi, 3'b000} +: 8] = push_byte;
                s_d.fill = s_q.fill + 1'b1;
            end
            if (flush && (s_q.fill != '0)) begin
                s_d.fpend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full  = (s_q.fill == burst_len);
    assign ready = !full && !s_q.fpend;
    assign want  = full || s_q.fpend;
    assign fill  = s_q.fill;
    assign data  = s_q.data;

    // R2: a lane never holds more than one burst
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill <= burst_len);
    // R8: bytes only enter a lane that signals ready
    a_r8_push_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ready);
    // R7: a pending flush always has bytes behind it
    a_r7_flush_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fpend |-> (s_q.fill != '0));
endmodule

// File: rtl/pbp_rr_arb.sv
module pbp_rr_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int LW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [LW-1:0] last;
    } st_t;

    st_t s_d, s_q;
    logic found;

    always_comb begin
        s_d   = s_q;
        gnt   = '0;
        found = 1'b0;
        if (en) begin
            for (int k = 1; k <= N; k++) begin
                if (!found && req[(int'(s_q.last) + k) % N]) begin
                    found = 1'b1;
                    gnt[(int'(s_q.last) + k) % N] = 1'b1;
                    s_d.last = LW'((int'(s_q.last) + k) % N);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.last <= LW'(N - 1);
        end else begin
            s_q <= s_d;
        end
    end

    // R10: at most one grant per cycle
    a_r10_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R10: a grant only goes to a waiting lane
    a_r10_gnt_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/payload_burst_packer.sv
module payload_burst_packer
    import pbp_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LOW_BURST  = 32,
    parameter int HIGH_BURST = 128,
    parameter int PKT_BYTES  = 188,
    parameter int HDR_BYTES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_low_bw,
    input  logic [PBP_NCLS-1:0][AW-1:0]   cfg_base,
    input  logic [PBP_NCLS-1:0][AW-1:0]   cfg_size,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [7:0]                    in_data,
    input  logic [1:0]                    in_class,
    input  logic                          in_sop,
    input  logic                          flush,
    output logic                          wr_req,
    output logic [AW-1:0]                 wr_addr,
    output logic [HIGH_BURST*8-1:0]       wr_data,
    output logic [$clog2(HIGH_BURST+1)-1:0] wr_count,
    input  logic                          wr_done
);
    localparam int CW = $clog2(HIGH_BURST + 1);
    localparam int DW = HIGH_BURST * 8;

    typedef struct packed {
        logic                        busy;
        logic [AW-1:0]               addr;
        logic [DW-1:0]               data;
        logic [CW-1:0]               count;
        logic [PBP_NCLS-1:0][AW-1:0] off;
    } st_t;

    st_t s_d, s_q;

    logic [CW-1:0]               burst_len;
    logic [PBP_NCLS-1:0]         lane_ready;
    logic [PBP_NCLS-1:0]         lane_want;
    logic [PBP_NCLS-1:0]         push;
    logic [PBP_NCLS-1:0]         gnt;
    logic [PBP_NCLS-1:0][CW-1:0] lane_fill;
    logic [PBP_NCLS-1:0][DW-1:0] lane_data;
    logic                        acc;
    logic                        pay;
    logic [AW-1:0]               nxt;

    assign burst_len = cfg_low_bw ? CW'(LOW_BURST) : CW'(HIGH_BURST);

    always_comb begin
        in_ready = 1'b1;
        for (int c = 0; c < PBP_NCLS; c++) begin
            if (in_class == 2'(c)) begin
                in_ready = lane_ready[c];
            end
        end
    end

    assign acc = in_valid && in_ready;

    pbp_hdr_strip #(
        .PKT_BYTES(PKT_BYTES),
        .HDR_BYTES(HDR_BYTES)
    ) i_strip (
        .clk  (clk),
        .rst_n(rst_n),
        .acc  (acc),
        .sop  (in_sop),
        .pay  (pay)
    );

    for (genvar g = 0; g < PBP_NCLS; g++) begin : g_lane
        assign push[g] = pay && (in_class == 2'(g));

        pbp_lane #(
            .MAX_BURST(HIGH_BURST)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push[g]),
            .push_byte(in_data),
            .burst_len(burst_len),
            .flush    (flush),
            .take     (gnt[g]),
            .ready    (lane_ready[g]),
            .want     (lane_want[g]),
            .fill     (lane_fill[g]),
            .data     (lane_data[g])
        );
    end

    pbp_rr_arb #(
        .N(PBP_NCLS)
    ) i_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (!s_q.busy),
        .req  (lane_want),
        .gnt  (gnt)
    );

    always_comb begin
        s_d = s_q;
        nxt = '0;
        if (s_q.busy && wr_done) begin
            s_d.busy = 1'b0;
        end
        for (int c = 0; c < PBP_NCLS; c++) begin
            if (gnt[c]) begin
                nxt        = s_q.off[c] + AW'(burst_len);
                s_d.busy   = 1'b1;
                s_d.addr   = cfg_base[c] + s_q.off[c];
                s_d.data   = lane_data[c];
                s_d.count  = lane_fill[c];
                s_d.off[c] = (nxt >= cfg_size[c]) ? '0 : nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_req   = s_q.busy;
    assign wr_addr  = s_q.addr;
    assign wr_data  = s_q.data;
    assign wr_count = s_q.count;

    // R9: a request waits, unchanged, for its done pulse
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_count) && $stable(wr_data)));
    // R9: one cycle without a request follows every completion
    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_done) |=> !wr_req);
    // R2: no burst is empty or longer than the selected size
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((wr_count != '0) && (wr_count <= burst_len)));
endmodule

// File: tb/test_payload_burst_packer.sv
module test_payload_burst_packer;
    localparam int AW = 16;
    localparam int HB = 128;
    localparam int CW = $clog2(HB + 1);
    localparam int MD = 512;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_low_bw = 1'b1;
    logic [2:0][AW-1:0]   cfg_base;
    logic [2:0][AW-1:0]   cfg_size;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [7:0]           in_data = '0;
    logic [1:0]           in_class = '0;
    logic                 in_sop = 1'b0;
    logic                 flush = 1'b0;
    logic                 wr_req;
    logic [AW-1:0]        wr_addr;
    logic [HB*8-1:0]      wr_data;
    logic [CW-1:0]        wr_count;
    logic                 wr_done = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mdl [3][MD];
    int wp [3];
    int rp [3];
    int exp_off [3];
    int flush_cnt [3];
    int order_log [16];
    int n_log = 0;
    int n_bursts = 0;
    int resp_delay = 0;
    int wait_cnt = 0;
    logic stall = 1'b0;
    logic [7:0] gctr = 8'h11;

    payload_burst_packer #(.AW(AW), .HIGH_BURST(HB)) i_payload_burst_packer (
        .clk(clk), .rst_n(rst_n), .cfg_low_bw(cfg_low_bw),
        .cfg_base(cfg_base), .cfg_size(cfg_size),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_class(in_class), .in_sop(in_sop), .flush(flush),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_count(wr_count), .wr_done(wr_done)
    );

    always #5 clk = ~clk;

    initial begin
        cfg_base[0] = 16'h1000; cfg_size[0] = 16'd256;
        cfg_base[1] = 16'h2000; cfg_size[1] = 16'd384;
        cfg_base[2] = 16'h4000; cfg_size[2] = 16'd1024;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int blen();
        return cfg_low_bw ? 32 : 128;
    endfunction

    task automatic check_burst();
        int c = -1;
        int cnt;
        int bad = 0;
        int bad_k = 0;
        int bad_a = 0;
        int bad_e = 0;
        for (int k = 0; k < 3; k++) begin
            if (int'(wr_addr) >= int'(cfg_base[k]) && int'(wr_addr) < int'(cfg_base[k]) + int'(cfg_size[k]))
                c = k;
        end
        check(c >= 0, "R6 address in a region", int'(wr_addr), 0);
        if (c < 0) return;
        n_bursts++;
        if (n_log < 16) begin
            order_log[n_log] = c;
            n_log++;
        end
        check(int'(wr_addr) == int'(cfg_base[c]) + exp_off[c], "R6 burst address",
              int'(wr_addr), int'(cfg_base[c]) + exp_off[c]);
        cnt = (flush_cnt[c] != 0) ? flush_cnt[c] : blen();
        check(int'(wr_count) == cnt, (flush_cnt[c] != 0) ? "R7 flush count" : "R2 burst count",
              int'(wr_count), cnt);
        flush_cnt[c] = 0;
        for (int k = 0; k < HB; k++) begin
            logic [7:0] e;
            e = (k < cnt) ? mdl[c][rp[c] % MD] : 8'h00;
            if (k < cnt) rp[c]++;
            if (bad == 0 && wr_data[8*k +: 8] != e) begin
                bad = 1; bad_k = k; bad_a = int'(wr_data[8*k +: 8]); bad_e = int'(e);
            end
        end
        if (bad != 0) $display("  first mismatch at byte %0d", bad_k);
        check(bad == 0, "R3 R5 payload order and zero padding", bad_a, bad_e);
        exp_off[c] = exp_off[c] + blen();
        if (exp_off[c] >= int'(cfg_size[c])) exp_off[c] = 0;
    endtask

    // completion responder
    initial begin
        forever begin
            @(negedge clk);
            wr_done = 1'b0;
            if (wr_req && !stall) begin
                if (wait_cnt >= resp_delay) begin
                    check_burst();
                    wr_done = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic send_byte(input logic [1:0] c, input logic s, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_sop = s; in_data = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic send_pkt(input logic [1:0] c, input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            send_byte(c, i == 0, gctr);
            if (c != 2'd3 && i >= 4 && i < 188) begin
                mdl[c][wp[c] % MD] = gctr;
                wp[c]++;
            end
            gctr = gctr + 8'd37;
        end
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 8) begin
            @(negedge clk);
            if (wr_req) quiet = 0; else quiet++;
        end
    endtask

    task automatic pulse_flush();
        for (int c = 0; c < 3; c++) flush_cnt[c] = wp[c] - rp[c];
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic do_reset(input logic low);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_low_bw = low;
        for (int c = 0; c < 3; c++) begin
            wp[c] = 0; rp[c] = 0; exp_off[c] = 0; flush_cnt[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        in_class = 2'd0;
        #1;
        check(wr_req == 1'b0, "R11 no request after reset", int'(wr_req), 0);
        check(in_ready == 1'b1, "R11 lanes ready after reset", int'(in_ready), 1);
    endtask

    task automatic sweep();
        logic [1:0] pat [10] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd0, 2'd2, 2'd1, 2'd0, 2'd0};
        int nb;
        for (int i = 0; i < 10; i++) begin
            resp_delay = i % 3;
            nb = (i == 3) ? 190 : 188;  // R1 trailing bytes past 188 are dropped
            send_pkt(pat[i], nb);
        end
        // R1 bytes before a start marker are dropped
        for (int i = 0; i < 5; i++) begin
            send_byte(2'd1, 1'b0, 8'hEE);
        end
        wait_idle();
        pulse_flush();
        wait_idle();
        for (int c = 0; c < 3; c++) begin
            check(rp[c] == wp[c], "R7 every packed byte written out", rp[c], wp[c]);
        end
        // R7 flush of empty lanes issues nothing
        nb = n_bursts;
        pulse_flush();
        repeat (12) @(negedge clk);
        check(n_bursts == nb && !wr_req, "R7 empty flush issues no burst", n_bursts, nb);
    endtask

    // main sequence
    initial begin
        logic [AW-1:0] held_addr;
        do_reset(1'b1);

        // R10 / R8 / R9: build up three waiting lanes behind a stalled port
        stall = 1'b1;
        resp_delay = 0;
        send_pkt(2'd2, 36);
        repeat (3) @(negedge clk);
        held_addr = wr_addr;
        send_pkt(2'd0, 36);
        send_pkt(2'd1, 36);
        send_pkt(2'd2, 36);
        repeat (4) @(negedge clk);
        check(wr_req == 1'b1 && wr_addr == held_addr, "R9 request held while stalled",
              int'(wr_addr), int'(held_addr));
        in_class = 2'd0;
        #1;
        check(in_ready == 1'b0, "R8 full lane stalls its class", int'(in_ready), 0);
        in_class = 2'd3;
        #1;
        check(in_ready == 1'b1, "R4 class 3 always accepted", int'(in_ready), 1);
        stall = 1'b0;
        wait_idle();
        check(n_log == 4, "R10 burst count in arbitration test", n_log, 4);
        check(order_log[0] == 2, "R10 first grant", order_log[0], 2);
        check(order_log[1] == 0, "R10 second grant", order_log[1], 0);
        check(order_log[2] == 1, "R10 third grant", order_log[2], 1);
        check(order_log[3] == 2, "R10 fourth grant", order_log[3], 2);

        // R8 back-pressure for one class leaves another open
        stall = 1'b1;
        send_pkt(2'd1, 36);
        send_pkt(2'd1, 36);
        @(negedge clk);
        in_class = 2'd1;
        #1;
        check(in_ready == 1'b0, "R8 waiting lane stalls", int'(in_ready), 0);
        in_class = 2'd2;
        #1;
        check(in_ready == 1'b1, "R8 other class unaffected", int'(in_ready), 1);
        stall = 1'b0;
        wait_idle();

        sweep();

        do_reset(1'b0);
        sweep();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule